// File: doc/BRIEF.md
# Serial Command Frame Parser

This block sits behind a UART byte receiver and turns four-byte command frames into 16-bit control words for a four-channel, 12-bit serial DAC. Bytes arrive on an 8-bit bus, and a one-cycle strobe marks each one. The parser stays idle until it sees a sync byte. It then takes the next three strobed bytes as payload: a channel select byte, a byte that carries the upper nibble of the code, and a byte that carries the lower eight bits of the code.

After the last payload byte, the block registers a finished word. The word holds the channel address, a power-down bit fixed high, a load-control bit fixed low and the 12-bit code. A one-cycle valid pulse goes with it. A downstream SPI shifter can start a DAC update on that pulse. The word then stays on the output until the next complete frame. Any line noise that arrives before a sync byte is dropped.

Top module: `cmdp_frame_parser`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a clock edge, the parser returns to idle. From the cycle after that edge, `word_out` reads 0x0000 and `word_valid` reads 0.
- R2: While idle, any strobed byte other than the sync value (default 0xAA) is dropped. It produces no `word_valid` pulse and leaves `word_out` unchanged.
- R3: Once a sync byte has been accepted, the next three strobed bytes are always taken as payload, whatever their value, 0xAA included.
- R4: `word_out[15:14]` equals bits [1:0] of the first payload byte. Bits [7:2] of that byte have no effect.
- R5: In every assembled word, `word_out[13]` (power-down) is 1 and `word_out[12]` (load control) is 0.
- R6: `word_out[11:8]` equals bits [7:4] of the second payload byte, and `word_out[7:0]` equals the third payload byte. Bits [3:0] of the second payload byte have no effect.
- R7: `word_valid` is high for exactly one cycle: the cycle right after the clock edge that samples the third payload byte strobe. The new word appears in that same cycle.
- R8: Outside a `word_valid` cycle, `word_out` holds its last value.
- R9: Bytes strobed on consecutive cycles are all accepted. A new frame may begin with the very next byte after a completed frame.
- R10: Idle cycles (strobe low) between the bytes of a frame do not change the result.
- R11: The frame AA 00 A0 3D yields `word_out` = 0x2A3D, which is channel 0 with code 0xA3D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_vld | input | 1 | One-cycle strobe marking a valid received byte |
| byte_data | input | 8 | Received byte |
| word_valid | output | 1 | One-cycle pulse marking a new control word |
| word_out | output | 16 | Assembled DAC control word |

## Verification
The assertions assume that `byte_vld` is a clean, known level at each clock edge. They also assume that reset is held for at least two edges, so that the output word is defined before the first checked cycle. The bench meets both assumptions: it drives every input on the falling edge, starts with a multi-cycle reset, and sends bytes only through a task that raises the strobe for exactly one cycle. Gaps come from explicit idle cycles, and frames also run back to back with no gap at all.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int NIB_W   = 4;
    localparam int CODE_W  = NIB_W + BYTE_W;
    localparam int WORD_W  = ADDR_W + 2 + CODE_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_HIGH = 2'd2,
        PH_LOW  = 2'd3
    } phase_t;

    typedef struct packed {
        logic [ADDR_W-1:0] chan;
        logic              pwr;
        logic              load;
        logic [CODE_W-1:0] code;
    } dac_word_t;

    function automatic dac_word_t build_word(
        input logic [ADDR_W-1:0] chan,
        input logic              pwr,
        input logic              load,
        input logic [NIB_W-1:0]  hi_nib,
        input logic [BYTE_W-1:0] lo_byte
    );
        dac_word_t w;
        w.chan = chan;
        w.pwr  = pwr;
        w.load = load;
        w.code = {hi_nib, lo_byte};
        return w;
    endfunction

endpackage

// File: rtl/cmdp_phase_ctrl.sv
module cmdp_phase_ctrl
    import cmdp_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'hAA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output phase_t            phase,
    output logic              frame_done
);

    phase_t phase_q;
    phase_t phase_d;

    always_comb begin
        phase_d = phase_q;
        if (byte_vld) begin
            unique case (phase_q)
                PH_IDLE: if (byte_data == SYNC_BYTE) phase_d = PH_ADDR;
                PH_ADDR: phase_d = PH_HIGH;
                PH_HIGH: phase_d = PH_LOW;
                PH_LOW:  phase_d = PH_IDLE;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase      = phase_q;
    assign frame_done = byte_vld && (phase_q == PH_LOW);

endmodule

// File: rtl/cmdp_field_latch.sv
module cmdp_field_latch
    import cmdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  phase_t            phase,
    input  logic [ADDR_W-1:0] addr_bits,
    input  logic [NIB_W-1:0]  nib_bits,
    output logic [ADDR_W-1:0] chan_q,
    output logic [NIB_W-1:0]  nib_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= '0;
            nib_q  <= '0;
        end else if (byte_vld) begin
            if (phase == PH_ADDR) chan_q <= addr_bits;
            if (phase == PH_HIGH) nib_q  <= nib_bits;
        end
    end

endmodule

// File: rtl/cmdp_word_reg.sv
module cmdp_word_reg
    import cmdp_pkg::*;
#(
    parameter logic PWR_LEVEL  = 1'b1,
    parameter logic LOAD_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_done,
    input  logic [ADDR_W-1:0] chan,
    input  logic [NIB_W-1:0]  hi_nib,
    input  logic [BYTE_W-1:0] lo_byte,
    output dac_word_t         word_q,
    output logic              valid_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= frame_done;
            if (frame_done) begin
                word_q <= build_word(chan, PWR_LEVEL, LOAD_LEVEL, hi_nib, lo_byte);
            end
        end
    end

endmodule

// File: rtl/cmdp_frame_parser.sv
module cmdp_frame_parser
    import cmdp_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SYNC_BYTE  = 8'hAA,
    parameter logic              PWR_LEVEL  = 1'b1,
    parameter logic              LOAD_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_out
);

    phase_t            phase;
    logic              frame_done;
    logic [ADDR_W-1:0] chan_q;
    logic [NIB_W-1:0]  nib_q;
    dac_word_t         word_q;

    cmdp_phase_ctrl #(
        .SYNC_BYTE (SYNC_BYTE)
    ) u_phase (
        .clk        (clk),
        .rst        (rst),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .phase      (phase),
        .frame_done (frame_done)
    );

    cmdp_field_latch u_fields (
        .clk       (clk),
        .rst       (rst),
        .byte_vld  (byte_vld),
        .phase     (phase),
        .addr_bits (byte_data[ADDR_W-1:0]),
        .nib_bits  (byte_data[BYTE_W-1 -: NIB_W]),
        .chan_q    (chan_q),
        .nib_q     (nib_q)
    );

    cmdp_word_reg #(
        .PWR_LEVEL  (PWR_LEVEL),
        .LOAD_LEVEL (LOAD_LEVEL)
    ) u_word (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .chan       (chan_q),
        .hi_nib     (nib_q),
        .lo_byte    (byte_data),
        .word_q     (word_q),
        .valid_q    (word_valid)
    );

    assign word_out = word_q;

endmodule

// File: rtl/cmdp_frame_parser_chk.sv
module cmdp_frame_parser_chk (
    input logic        clk,
    input logic        rst,
    input logic        byte_vld,
    input logic        word_valid,
    input logic [15:0] word_out
);

    logic live_q;

    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    // R1: reset clears the outputs by the next cycle
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!word_valid && word_out == 16'h0000));

    // R5: fixed control bits in every announced word
    assert_ctrl_bits_R5: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (word_out[13] == 1'b1 && word_out[12] == 1'b0));

    // R7: the valid pulse never lasts two cycles
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    // R7: a pulse always follows a sampled byte strobe
    assert_pulse_after_byte_R7: assert property (@(posedge clk) disable iff (rst)
        (live_q && word_valid) |-> $past(byte_vld));

    // R8: the word is steady between pulses
    assert_word_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (live_q && !word_valid) |-> $stable(word_out));

endmodule

bind cmdp_frame_parser cmdp_frame_parser_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .byte_vld   (byte_vld),
    .word_valid (word_valid),
    .word_out   (word_out)
);

// File: tb/cmdp_frame_parser_test.sv
module cmdp_frame_parser_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        word_valid;
    logic [15:0] word_out;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int          m_cnt = 0;
    int          m_b[3];
    logic        m_valid = 1'b0;
    logic [15:0] m_word = 16'h0;

    always #2.5 clk = ~clk;

    cmdp_frame_parser uut (
        .clk        (clk),
        .rst        (rst),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .word_valid (word_valid),
        .word_out   (word_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_cnt = 0; m_valid = 1'b0; m_word = 16'h0;
        end else begin
            m_valid = 1'b0;
            if (byte_vld) begin
                if (m_cnt == 0) begin
                    if (byte_data == 8'hAA) m_cnt = 1;
                end else begin
                    m_b[m_cnt-1] = int'(byte_data);
                    m_cnt = m_cnt + 1;
                    if (m_cnt == 4) begin
                        m_word = 16'((m_b[0] % 4) * 16384 + 8192 + (m_b[1] / 16) * 256 + m_b[2]);
                        m_valid = 1'b1;
                        m_cnt = 0;
                    end
                end
            end
        end
    end

    // per-cycle comparison away from the active edge (R4 R5 R6 R7 R8)
    always @(negedge clk) begin
        if (!rst && cycles > 0) begin
            check(word_valid === m_valid, "R7 valid vs model", int'(word_valid), int'(m_valid));
            check(word_out === m_word, "R4/R5/R6/R8 word vs model", int'(word_out), int'(m_word));
        end
        if (word_valid === 1'b1) pulses++;
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic put(input logic [7:0] b);
        byte_vld  = 1'b1;
        byte_data = b;
        @(negedge clk);
        byte_vld  = 1'b0;
        byte_data = 8'h00;
    endtask

    task automatic frame(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                         input logic [7:0] d, input int gap);
        put(a); idle(gap);
        put(b); idle(gap);
        put(c); idle(gap);
        put(d);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        // R1: reset state
        check(word_out === 16'h0000, "R1 reset word", int'(word_out), 0);
        check(word_valid === 1'b0, "R1 reset valid", int'(word_valid), 0);

        // R11: worked example, back to back
        frame(8'hAA, 8'h00, 8'hA0, 8'h3D, 0);
        check(word_valid === 1'b1, "R7 pulse cycle", int'(word_valid), 1);
        check(word_out === 16'h2A3D, "R11 example word", int'(word_out), 16'h2A3D);
        idle(1);
        check(word_valid === 1'b0, "R7 pulse ends", int'(word_valid), 0);

        // R2: noise while idle
        pulses = 0;
        put(8'h55); put(8'h00); put(8'hFF); put(8'hAB); idle(4);
        check(pulses == 0, "R2 noise pulses", pulses, 0);
        check(word_out === 16'h2A3D, "R2 noise word unchanged", int'(word_out), 16'h2A3D);

        // R3 R4 R6: sync value as payload, ignored bits set
        frame(8'hAA, 8'hAA, 8'hAA, 8'hAA, 0);
        check(word_out === 16'hAAAA, "R3 sync as payload", int'(word_out), 16'hAAAA);
        frame(8'hAA, 8'hFF, 8'h5F, 8'h81, 0);
        check(word_out === 16'hE581, "R4/R6 ignored bits", int'(word_out), 16'hE581);

        // R10: gaps between bytes
        frame(8'hAA, 8'h02, 8'h7C, 8'h10, 5);
        check(word_out === 16'hA710, "R10 gapped frame", int'(word_out), 16'hA710);
        idle(6);
        check(word_out === 16'hA710, "R8 hold after frame", int'(word_out), 16'hA710);

        // R9: frames with no gap between them
        pulses = 0;
        frame(8'hAA, 8'h01, 8'h30, 8'h44, 0);
        check(word_out === 16'h6344, "R9 first of pair", int'(word_out), 16'h6344);
        frame(8'hAA, 8'h03, 8'hF0, 8'hFF, 0);
        check(word_out === 16'hEFFF, "R9 second of pair", int'(word_out), 16'hEFFF);
        idle(2);
        check(pulses == 2, "R9 pulse count", pulses, 2);

        // R1: reset mid-frame then fresh frame
        put(8'hAA); put(8'h01);
        rst = 1'b1; idle(2); rst = 1'b0;
        check(word_out === 16'h0000, "R1 reset mid-frame", int'(word_out), 0);
        put(8'h12); put(8'h34); idle(3);
        check(word_out === 16'h0000, "R1 no stale frame", int'(word_out), 0);
        frame(8'hAA, 8'h00, 8'h00, 8'h00, 1);
        check(word_out === 16'h2000, "R5 ctrl bits zero code", int'(word_out), 16'h2000);
        idle(3);
        done = 1;
        finish_run();
    end

    initial begin
        wait (cycles > 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            finish_run();
        end
    end

endmodule